// File: doc/BRIEF.md
# Rectangle fill command engine

This engine sits behind a small register window. The host writes 32-bit command and data words to one port, and the engine queues them in a shallow input FIFO. A packet decoder reads a solid fill command from the queue and takes two further words for each rectangle. A raster scanner then steps over every covered pixel. For each pixel it presents one write (x, y, foreground colour) on a valid/ready output toward the frame buffer side.

A read at the same offset as the command port returns a status word. The word holds the busy flag, a buffer-empty flag, the retrace input and the number of free input slots. Host software issues a fill and then polls until busy is low. A foreground colour register, which can be read back, sets the colour of every emitted pixel.

The decoder is a four-state machine:
- **CMD** (`ST_CMD`) waits for a command word. It moves to **POS** on a fill opcode with a non-zero count, and stays in CMD on any other word.
- **POS** (`ST_POS`) takes the origin word and then always moves to **SIZE**.
- **SIZE** (`ST_SIZE`) takes the extent word.
  - On a non-empty rectangle it moves to **PIX**.
  - On an empty rectangle it moves back to POS, or to CMD if that was the last rectangle.
- **PIX** (`ST_PIX`) emits pixels. After the last pixel is accepted it returns to POS when rectangles remain, and to CMD otherwise.

Top module: `rectfill_engine`

## Requirements
- R1: A write with `wr_addr`=0x00 pushes `wr_data` into the input FIFO. With `rd_addr`=0x00, `rd_data` returns status: bit 0 = retrace, bit 2 = busy, bit 4 = FIFO empty, bits 31:16 = free slots. All other bits read 0.
- R2: After reset the status reads busy=0, empty=1 and free=DEPTH, `px_valid` is 0, and the colour register at offset 0x44 reads 0.
- R3: Free space equals DEPTH minus the words held. A push and a pop in the same cycle leave it unchanged. A write while free space is 0 is dropped.
- R4: A command word with bits 31:24 = 0x86 starts a fill. Its bits 15:0 give the rectangle count N, and each rectangle takes two further words.
- R5: In the origin word, bits 31:16 give X and bits 15:0 give Y. In the extent word, bits 31:16 give H and bits 15:0 give W. Pixels cover x = X..X+W-1 and y = Y..Y+H-1 (16-bit wrap), emitted left to right within a row and rows top to bottom.
- R6: A write to offset 0x44 sets the foreground colour, which reads back at 0x44 and appears on `px_color` of every pixel.
- R7: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_x` and `px_y` hold.
- R8: Busy is high from the cycle after a word is accepted until the last pixel of the last rectangle has been accepted. `px_valid` is never high while busy is low.
- R9: A rectangle with W=0 or H=0 emits no pixels, and a command with N=0 emits no pixels.
- R10: A command word with any opcode other than 0x86 is dropped alone, and the next word is decoded as a command.
- R11: Status bit 0 follows the `retrace` input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (status or colour) |
| retrace | input | 1 | Vertical retrace indication |
| px_valid | output | 1 | Pixel write valid |
| px_ready | input | 1 | Pixel write accepted downstream |
| px_x | output | 16 | Pixel X coordinate |
| px_y | output | 16 | Pixel Y coordinate |
| px_color | output | 32 | Pixel colour |

## Verification
The host can push a word in the same cycle as the decoder pops one. In that case the FIFO occupancy, and so the reported free space, must stay the same. The bench provokes this by writing the words of a packet on back-to-back cycles. It reads free space after the second word: at that point the first word is being popped as the second arrives, so free space must read DEPTH-1. A second collision is provoked by stalling the pixel output while the host fills the queue to overflow. That test judges three things: free space reaches 0, the surplus word is dropped, and the held pixel stays stable.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_COLOR = 8'h44;
    localparam logic [7:0] OP_FILL   = 8'h86;

    localparam int SB_RETRACE = 0;
    localparam int SB_BUSY    = 2;
    localparam int SB_EMPTY   = 4;
    localparam int SB_FREE    = 16;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_POS  = 2'd1,
        ST_SIZE = 2'd2,
        ST_PIX  = 2'd3
    } dec_state_t;
endpackage

// File: rtl/rf_fifo.sv
module rf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign empty   = (count == '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl
    import rf_pkg::*;
#(
    parameter int CORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [31:0]       fifo_word,
    output logic              fifo_pop,
    input  logic              px_ready,
    output logic              px_valid,
    output logic [CORD_W-1:0] px_x,
    output logic [CORD_W-1:0] px_y,
    output logic              active
);
    dec_state_t        st, nxt;
    logic [15:0]       rects_left;
    logic [CORD_W-1:0] x0, wid, col_left, row_left;
    logic              last_rect, zero_size, pix_done, is_fill;

    assign last_rect = (rects_left == 16'd1);
    assign zero_size = (fifo_word[15:0] == '0) || (fifo_word[31:16] == '0);
    assign pix_done  = px_ready && (col_left == '0) && (row_left == '0);
    assign is_fill   = (fifo_word[31:24] == OP_FILL) && (fifo_word[15:0] != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_CMD;
        else        st <= nxt;
    end

    // next state and pop
    always_comb begin
        nxt      = st;
        fifo_pop = 1'b0;
        unique case (st)
            ST_CMD: if (!fifo_empty) begin
                fifo_pop = 1'b1;
                if (is_fill) nxt = ST_POS;
            end
            ST_POS: if (!fifo_empty) begin
                fifo_pop = 1'b1;
                nxt      = ST_SIZE;
            end
            ST_SIZE: if (!fifo_empty) begin
                fifo_pop = 1'b1;
                if (!zero_size)     nxt = ST_PIX;
                else if (last_rect) nxt = ST_CMD;
                else                nxt = ST_POS;
            end
            ST_PIX: if (pix_done) nxt = last_rect ? ST_CMD : ST_POS;
            default: nxt = ST_CMD;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rects_left <= '0;
            x0         <= '0;
            wid        <= '0;
            col_left   <= '0;
            row_left   <= '0;
            px_x       <= '0;
            px_y       <= '0;
        end else begin
            unique case (st)
                ST_CMD: if (!fifo_empty && is_fill) rects_left <= fifo_word[15:0];
                ST_POS: if (!fifo_empty) begin
                    x0   <= fifo_word[31:16];
                    px_y <= fifo_word[15:0];
                end
                ST_SIZE: if (!fifo_empty) begin
                    if (zero_size) begin
                        rects_left <= rects_left - 1'b1;
                    end else begin
                        wid      <= fifo_word[15:0];
                        col_left <= fifo_word[15:0] - 1'b1;
                        row_left <= fifo_word[31:16] - 1'b1;
                        px_x     <= x0;
                    end
                end
                ST_PIX: if (px_ready) begin
                    if (col_left != '0) begin
                        px_x     <= px_x + 1'b1;
                        col_left <= col_left - 1'b1;
                    end else if (row_left != '0) begin
                        px_x     <= x0;
                        px_y     <= px_y + 1'b1;
                        col_left <= wid - 1'b1;
                        row_left <= row_left - 1'b1;
                    end else begin
                        rects_left <= rects_left - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign px_valid = (st == ST_PIX);
    assign active   = (st != ST_CMD);
endmodule

// File: rtl/rectfill_engine.sv
module rectfill_engine
    import rf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        retrace,
    output logic        px_valid,
    input  logic        px_ready,
    output logic [15:0] px_x,
    output logic [15:0] px_y,
    output logic [31:0] px_color
);
    logic [31:0]   fg_color, fifo_word, status;
    logic          fifo_empty, fifo_pop, active, busy;
    logic [CW-1:0] fifo_count;

    rf_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en && (wr_addr == OFS_CMD)),
        .din   (wr_data),
        .pop   (fifo_pop),
        .dout  (fifo_word),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    rf_ctrl #(.CORD_W(16)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .fifo_pop   (fifo_pop),
        .px_ready   (px_ready),
        .px_valid   (px_valid),
        .px_x       (px_x),
        .px_y       (px_y),
        .active     (active)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                               fg_color <= '0;
        else if (wr_en && wr_addr == OFS_COLOR)   fg_color <= wr_data;
    end

    assign busy     = active || !fifo_empty;
    assign px_color = fg_color;

    always_comb begin
        status                  = '0;
        status[SB_RETRACE]      = retrace;
        status[SB_BUSY]         = busy;
        status[SB_EMPTY]        = fifo_empty;
        status[SB_FREE +: 16]   = 16'(DEPTH) - 16'(fifo_count);
    end

    always_comb begin
        unique case (rd_addr)
            OFS_CMD:   rd_data = status;
            OFS_COLOR: rd_data = fg_color;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [7:0]    wr_addr,
    input logic          px_valid,
    input logic          px_ready,
    input logic [15:0]   px_x,
    input logic [15:0]   px_y,
    input logic          busy,
    input logic [CW-1:0] fifo_count
);
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid && !px_ready |=> px_valid && $stable(px_x) && $stable(px_y));

    a_r8_no_pixel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> busy);

    a_r8_busy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == 8'h00 && fifo_count != CW'(DEPTH) |=> busy);

    a_r3_bounded_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !px_valid && fifo_count == '0);
endmodule

bind rectfill_engine rf_checker #(.DEPTH(DEPTH)) u_rf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .px_valid   (px_valid),
    .px_ready   (px_ready),
    .px_x       (px_x),
    .px_y       (px_y),
    .busy       (busy),
    .fifo_count (fifo_count)
);

// File: tb/test_rectfill_engine.sv
module test_rectfill_engine;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        retrace = 1'b0;
    logic        px_valid;
    logic        px_ready = 1'b1;
    logic [15:0] px_x, px_y;
    logic [31:0] px_color;

    int errors = 0;
    int checks = 0;
    int pix_n = 0;
    logic [15:0] got_x [64];
    logic [15:0] got_y [64];
    logic [31:0] got_c [64];

    always #10 clk = ~clk;

    rectfill_engine #(.DEPTH(DEPTH)) i_rectfill_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .retrace(retrace), .px_valid(px_valid), .px_ready(px_ready),
        .px_x(px_x), .px_y(px_y), .px_color(px_color)
    );

    always @(negedge clk) begin
        if (rst_n && px_valid && px_ready) begin
            if (pix_n < 64) begin
                got_x[pix_n] = px_x;
                got_y[pix_n] = px_y;
                got_c[pix_n] = px_color;
            end
            pix_n = pix_n + 1;
        end
    end

    // {X, Y, W, H}
    localparam logic [63:0] VEC [6] = '{
        {16'd10,    16'd20, 16'd3, 16'd2},
        {16'd0,     16'd0,  16'd1, 16'd1},
        {16'd100,   16'd5,  16'd4, 16'd1},
        {16'd7,     16'd7,  16'd1, 16'd3},
        {16'd65534, 16'd3,  16'd3, 16'd1},
        {16'd3,     16'd3,  16'd0, 16'd5}
    };

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    function automatic logic [31:0] st_word(input bit rt, input bit bz, input bit em, input int fr);
        return {16'(fr), 11'd0, em, 1'b0, bz, 1'b0, rt};
    endfunction

    task automatic wait_idle();
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (rd_data[2] == 1'b0) break;
        end
    endtask

    task automatic fill1(input logic [15:0] x, input logic [15:0] y, input logic [15:0] w, input logic [15:0] h);
        wr(8'h00, 32'h8600_0001);
        wr(8'h00, {x, y});
        wr(8'h00, {h, w});
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(rd_data == st_word(0, 0, 1, DEPTH), "R2 status", rd_data, st_word(0, 0, 1, DEPTH));
        chk(px_valid == 1'b0, "R2 px_valid", 32'(px_valid), 0);
        rd_addr = 8'h44; #1;
        chk(rd_data == 0, "R2 colour", rd_data, 0);
        rd_addr = 8'h00;
        // R11 / R1: retrace bit
        retrace = 1'b1; #1;
        chk(rd_data == st_word(1, 0, 1, DEPTH), "R11 retrace high", rd_data, st_word(1, 0, 1, DEPTH));
        retrace = 1'b0; #1;
        chk(rd_data[0] == 1'b0, "R11 retrace low", rd_data, st_word(0, 0, 1, DEPTH));

        // table walk: R5, R6, R9
        foreach (VEC[i]) begin
            logic [15:0] vx, vy, vw, vh;
            int bad_pos, bad_col, k;
            logic [31:0] col;
            {vx, vy, vw, vh} = VEC[i];
            col = 32'hC0DE_0000 + 32'(i);
            wr(8'h44, col);
            rd_addr = 8'h44; #1;
            chk(rd_data == col, "R6 colour readback", rd_data, col);
            rd_addr = 8'h00;
            pix_n = 0;
            fill1(vx, vy, vw, vh);
            chk(pix_n == int'(vw) * int'(vh), "R5/R9 pixel count", 32'(pix_n), 32'(int'(vw) * int'(vh)));
            bad_pos = 0; bad_col = 0; k = 0;
            for (int r = 0; r < int'(vh); r++) begin
                for (int c = 0; c < int'(vw); c++) begin
                    if (k < 64 && k < pix_n) begin
                        if (got_x[k] != vx + 16'(c) || got_y[k] != vy + 16'(r)) bad_pos++;
                        if (got_c[k] != col) bad_col++;
                    end
                    k++;
                end
            end
            chk(bad_pos == 0, "R5 scan order", 32'(bad_pos), 0);
            chk(bad_col == 0, "R6 pixel colour", 32'(bad_col), 0);
            chk(rd_data == st_word(0, 0, 1, DEPTH), "R8 idle after fill", rd_data, st_word(0, 0, 1, DEPTH));
        end

        // R3: push and pop in the same cycle
        wr(8'h00, 32'h8600_0001);
        wr(8'h00, {16'd1, 16'd1});
        #1;
        chk(rd_data[31:16] == 16'(DEPTH - 1), "R3 push+pop free", 32'(rd_data[31:16]), 32'(DEPTH - 1));
        pix_n = 0;
        wr(8'h00, {16'd1, 16'd2});
        wait_idle();
        chk(pix_n == 2, "R1 pushed packet", 32'(pix_n), 2);

        // R4: two rectangles in one command
        pix_n = 0;
        wr(8'h00, 32'h8600_0002);
        wr(8'h00, {16'd5, 16'd6});
        wr(8'h00, {16'd1, 16'd2});
        wr(8'h00, {16'd40, 16'd41});
        wr(8'h00, {16'd2, 16'd1});
        wait_idle();
        chk(pix_n == 4, "R4 two-rect count", 32'(pix_n), 4);
        chk(got_x[2] == 16'd40 && got_y[3] == 16'd42, "R4 second rect", {got_x[2], got_y[3]}, {16'd40, 16'd42});

        // R9: count of zero
        pix_n = 0;
        wr(8'h00, 32'h8600_0000);
        wait_idle();
        chk(pix_n == 0, "R9 zero count", 32'(pix_n), 0);

        // R10: unknown opcode dropped alone
        pix_n = 0;
        wr(8'h00, 32'h1200_0001);
        fill1(16'd9, 16'd9, 16'd1, 16'd1);
        chk(pix_n == 1 && got_x[0] == 16'd9, "R10 unknown opcode", 32'(pix_n), 1);

        // R7 / R8 / R3: stalled output and overflow
        px_ready = 1'b0;
        pix_n = 0;
        wr(8'h00, 32'h8600_0001);
        wr(8'h00, {16'd20, 16'd30});
        wr(8'h00, {16'd1, 16'd2});
        repeat (5) @(negedge clk);
        chk(px_valid && px_x == 16'd20 && px_y == 16'd30, "R7 first pixel held", {px_x, px_y}, {16'd20, 16'd30});
        chk(rd_data == st_word(0, 1, 1, DEPTH), "R8 busy while stalled", rd_data, st_word(0, 1, 1, DEPTH));
        wr(8'h00, 32'h8600_0001);
        wr(8'h00, {16'd50, 16'd50});
        #1;
        chk(rd_data[31:16] == 16'(DEPTH - 2) && rd_data[4] == 1'b0, "R3 free after two", rd_data, st_word(0, 1, 0, DEPTH - 2));
        wr(8'h00, {16'd1, 16'd1});
        wr(8'h00, 32'h0000_0000);
        wr(8'h00, 32'h8600_0001);
        #1;
        chk(rd_data[31:16] == 16'd0, "R3 full", 32'(rd_data[31:16]), 0);
        chk(px_valid && px_x == 16'd20 && px_y == 16'd30, "R7 still held", {px_x, px_y}, {16'd20, 16'd30});
        @(negedge clk);
        px_ready = 1'b1;
        wait_idle();
        chk(pix_n == 3, "R3 overflow word dropped", 32'(pix_n), 3);
        chk(got_x[1] == 16'd21 && got_x[2] == 16'd50, "R7 order after stall", {got_x[1], got_x[2]}, {16'd21, 16'd50});
        chk(rd_data == st_word(0, 0, 1, DEPTH), "R8 idle at end", rd_data, st_word(0, 0, 1, DEPTH));

        finish_up();
    end
endmodule